// File: doc/BRIEF.md
# Accumulating Bang-Bang Phase Detector

The block measures the phase relation between a reference clock and a feedback clock for a software-driven PLL. Each clock first passes through its own integer divider. Each divider output is a toggle that inverts once every N input cycles, so the two dividers can be set independently and a loop can lock the clocks at an N:M frequency ratio.

On every rising edge of the divided reference, the block samples the synchronised divided-feedback level. A high level counts as +1 (feedback early) and a low level counts as -1 (feedback late). The decisions are summed in a signed accumulator. A gating window lasts 2^LOG2_GATE selected-reference cycles. At the end of each window the sum is latched and the accumulator is cleared. The sample then crosses into the system clock domain and appears as a signed word with a one-cycle valid strobe, ready for the servo software.

A larger gating exponent gives fewer samples, each integrated over a longer time, and so a narrower loop bandwidth. The reference is picked from several clock inputs by an index. A channel that is not in use is held off with the enable, and then it produces no samples.

Top module: `bbpd_accum`

## Requirements
- R1: While reset is asserted and right after it, `err_o` is 0 and `err_valid_o` is 0.
- R2: The divided reference inverts every REF_DIV selected-reference cycles, and one decision is made on each of its rising edges. With the divided feedback held low and 2·REF_DIV dividing 2^LOG2_GATE, every sample equals -(2^LOG2_GATE / (2·REF_DIV)). No sample ever exceeds that magnitude.
- R3: A decision adds +1 when the synchronised divided feedback is high and -1 when it is low. With the divided feedback held high, every sample equals +(2^LOG2_GATE / (2·REF_DIV)).
- R4: The divided feedback inverts after every FB_DIV feedback-clock rising edges, so after n edges since reset its level is floor(n/FB_DIV) mod 2. When the divided feedback has twice the period of the divided reference, the decisions alternate and each sample is 0.
- R5: Exactly one sample is produced per 2^LOG2_GATE selected-reference cycles while enabled, so successive strobes are that many reference periods apart, give or take one system cycle.
- R6: `err_valid_o` is high for a single system clock cycle per sample.
- R7: `err_o` changes only in a cycle where `err_valid_o` is high, and it holds its value until the next sample.
- R8: While `enable_i` is low, no new samples appear. The divider, window and accumulator restart on re-enable, so the first sample after re-enable covers a complete window.
- R9: `ref_sel_i` is the index of the reference input in use. Clocks on the other reference inputs have no effect. The index may change only while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock; the sample output is registered on it |
| rst_n_i | input | 1 | Asynchronous active-low reset for all clock domains |
| ref_clk_i | input | NUM_REF | Candidate reference clocks |
| ref_sel_i | input | SEL_W | Index of the reference clock in use |
| fb_clk_i | input | 1 | Feedback clock from the controlled oscillator |
| enable_i | input | 1 | Channel enable (system domain) |
| err_o | output | LOG2_GATE+2 | Signed accumulated phase error of the last window |
| err_valid_o | output | 1 | One-cycle strobe marking a new `err_o` |

## Verification
A wrong divider count or a wrong window length changes the value of every clean sample. It also changes the spacing between strobes, so the fault is visible at the second strobe after the stimulus settles. An inverted decision sign flips the sign of the steady-state samples. A handshake fault shows within a few system cycles of a window end, as a strobe longer than one cycle or an error word that moves without a strobe. An accumulator that is not cleared at window end, or not restarted on re-enable, gives magnitudes beyond the per-window decision count in the next sample.

// File: rtl/bbpd_accum.sv
module bbpd_accum #(
  parameter int NUM_REF   = 2,
  parameter int REF_DIV   = 2,
  parameter int FB_DIV    = 3,
  parameter int LOG2_GATE = 5,
  localparam int SEL_W    = (NUM_REF > 1) ? $clog2(NUM_REF) : 1,
  localparam int ERR_W    = LOG2_GATE + 2
) (
  input  logic                    sys_clk_i,
  input  logic                    rst_n_i,
  input  logic [NUM_REF-1:0]      ref_clk_i,
  input  logic [SEL_W-1:0]        ref_sel_i,
  input  logic                    fb_clk_i,
  input  logic                    enable_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_valid_o
);
  localparam int RDW = $clog2(REF_DIV + 1);
  localparam int FDW = $clog2(FB_DIV + 1);

  logic ref_clk;
  assign ref_clk = ref_clk_i[ref_sel_i];

  // feedback divider, feedback domain
  logic [FDW-1:0] fb_cnt;
  logic           fb_div;
  always_ff @(posedge fb_clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      fb_cnt <= '0;
      fb_div <= 1'b0;
    end else if (fb_cnt == FDW'(FB_DIV - 1)) begin
      fb_cnt <= '0;
      fb_div <= ~fb_div;
    end else begin
      fb_cnt <= fb_cnt + 1'b1;
    end

  // reference domain
  logic [1:0]              en_sync, fb_sync;
  logic                    en_ref, fb_ref;
  logic [RDW-1:0]          rd_cnt;
  logic                    ref_div;
  logic [LOG2_GATE-1:0]    win;
  logic signed [ERR_W-1:0] acc, hold, step, sum_next;
  logic                    win_tgl, rise, last;

  assign en_ref   = en_sync[1];
  assign fb_ref   = fb_sync[1];
  assign rise     = (rd_cnt == RDW'(REF_DIV - 1)) && !ref_div;
  assign last     = &win;
  assign step     = fb_ref ? ERR_W'(1) : {ERR_W{1'b1}};
  assign sum_next = acc + (rise ? step : '0);

  always_ff @(posedge ref_clk or negedge rst_n_i)
    if (!rst_n_i) begin
      en_sync <= '0;
      fb_sync <= '0;
    end else begin
      en_sync <= {en_sync[0], enable_i};
      fb_sync <= {fb_sync[0], fb_div};
    end

  always_ff @(posedge ref_clk or negedge rst_n_i)
    if (!rst_n_i) begin
      rd_cnt  <= '0;
      ref_div <= 1'b0;
      win     <= '0;
      acc     <= '0;
      hold    <= '0;
      win_tgl <= 1'b0;
    end else if (!en_ref) begin
      rd_cnt  <= '0;
      ref_div <= 1'b0;
      win     <= '0;
      acc     <= '0;
    end else begin
      if (rd_cnt == RDW'(REF_DIV - 1)) begin
        rd_cnt  <= '0;
        ref_div <= ~ref_div;
      end else begin
        rd_cnt <= rd_cnt + 1'b1;
      end
      win <= win + 1'b1;
      if (last) begin
        hold    <= sum_next;
        acc     <= '0;
        win_tgl <= ~win_tgl;
      end else begin
        acc <= sum_next;
      end
    end

  // system domain: toggle handshake
  logic [2:0] tsync;
  logic       tedge;
  assign tedge = tsync[2] ^ tsync[1];

  always_ff @(posedge sys_clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      tsync       <= '0;
      err_o       <= '0;
      err_valid_o <= 1'b0;
    end else begin
      tsync       <= {tsync[1:0], win_tgl};
      err_valid_o <= tedge;
      if (tedge) err_o <= hold;
    end
endmodule

// File: rtl/bbpd_accum_chk.sv
module bbpd_accum_chk #(
  parameter int REF_DIV   = 2,
  parameter int LOG2_GATE = 5,
  localparam int ERR_W    = LOG2_GATE + 2,
  localparam int WIN      = 2 ** LOG2_GATE,
  localparam int MAXD     = WIN / (2 * REF_DIV) + 1
) (
  input logic                    sys_clk,
  input logic                    rst_n,
  input logic                    rclk,
  input logic                    en_ref,
  input logic                    tgl,
  input logic signed [ERR_W-1:0] err,
  input logic                    valid
);
  logic                 tq;
  logic [LOG2_GATE+1:0] cnt;
  logic                 flip;
  assign flip = tgl != tq;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      tq  <= 1'b0;
      cnt <= '0;
    end else begin
      tq <= tgl;
      if (!en_ref)   cnt <= '0;
      else if (flip) cnt <= 1;
      else           cnt <= cnt + 1'b1;
    end

  assert_window_len_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    flip |-> cnt == (LOG2_GATE+2)'(WIN));

  assert_single_strobe_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_err_hold_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !valid |-> $stable(err));

  assert_err_bound_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    valid |-> ($signed(err) <= MAXD && $signed(err) >= -MAXD));
endmodule

bind bbpd_accum bbpd_accum_chk #(.REF_DIV(REF_DIV), .LOG2_GATE(LOG2_GATE)) u_chk (
  .sys_clk(sys_clk_i), .rst_n(rst_n_i), .rclk(ref_clk), .en_ref(en_ref),
  .tgl(win_tgl), .err(err_o), .valid(err_valid_o));

// File: tb/sim_bbpd_accum.sv
`timescale 1ns/1ps
module sim_bbpd_accum;
  localparam int NUM_REF = 2, REF_DIV = 2, FB_DIV = 3, G = 5;
  localparam int ERR_W = G + 2;
  localparam int D = (2 ** G) / (2 * REF_DIV);
  localparam int GAP = (2 ** G) * 12 / 8;
  localparam int NV = 4;
  localparam int MODE_T[NV] = '{0, 1, 2, 0};
  localparam int SIGN_T[NV] = '{-1, 1, 0, -1};

  logic sys_clk = 0, rst_n = 0, enable = 0;
  logic ref_free = 0, fb_free = 0;
  logic r0_en = 1, r1_en = 1, r0_req = 1, fb_en = 0;
  logic [0:0] ref_sel = 0;
  logic [NUM_REF-1:0] ref_in;
  logic fb_clk;
  logic signed [ERR_W-1:0] err;
  logic valid;
  int fb_mode = 0, npulse = 0, checks = 0, errors = 0;
  bit done = 0;

  always #4 sys_clk = ~sys_clk;
  always #6 ref_free = ~ref_free;
  always #8 fb_free = ~fb_free;
  assign ref_in = {ref_free & r1_en, ref_free & r0_en};
  assign fb_clk = fb_free & fb_en;

  always @(negedge ref_free) r0_en <= r0_req;
  always @(posedge fb_clk or negedge rst_n)
    if (!rst_n) npulse = 0; else npulse = npulse + 1;
  always @(negedge fb_free)
    if (fb_mode == 2) fb_en <= 1'b1;
    else fb_en <= (((npulse / FB_DIV) % 2) != fb_mode);

  bbpd_accum #(.NUM_REF(NUM_REF), .REF_DIV(REF_DIV), .FB_DIV(FB_DIV), .LOG2_GATE(G)) u0 (
    .sys_clk_i(sys_clk), .rst_n_i(rst_n), .ref_clk_i(ref_in), .ref_sel_i(ref_sel),
    .fb_clk_i(fb_clk), .enable_i(enable), .err_o(err), .err_valid_o(valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge sys_clk); #1;
  endtask

  task automatic wait_valid(output bit got, output int cyc);
    got = 0; cyc = 0;
    for (int i = 0; i < 400; i++) begin
      tick(); cyc++;
      if (valid) begin got = 1; return; end
    end
  endtask

  task automatic expect_sample(input string req, input int exp);
    bit g; int c;
    wait_valid(g, c);
    chk(g && int'(err) == exp, req, g ? int'(err) : 9999, exp);
  endtask

  task automatic expect_quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (valid) seen++; end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    bit g; int c; logic signed [ERR_W-1:0] e; int moved;
    repeat (3) tick();
    chk(err == 0, "R1 err", int'(err), 0);
    chk(valid == 0, "R1 valid", int'(valid), 0);
    rst_n = 1; tick();
    chk(err == 0 && valid == 0, "R1 after release", int'(err), 0);
    enable = 1;

    for (int k = 0; k < NV; k++) begin
      fb_mode = MODE_T[k];
      wait_valid(g, c); wait_valid(g, c);
      for (int s = 0; s < 2; s++)
        expect_sample(k == 1 ? "R3 fb high" : (k == 2 ? "R4 half rate fb" : "R2 fb low"),
                      SIGN_T[k] * D);
    end

    wait_valid(g, c);
    wait_valid(g, c);
    chk(g && c >= GAP - 1 && c <= GAP + 1, "R5 spacing", c, GAP);

    e = err; moved = 0;
    tick();
    chk(valid == 0, "R6 strobe width", int'(valid), 0);
    for (int i = 0; i < 20; i++) begin tick(); if (err != e) moved++; end
    chk(moved == 0, "R7 hold", moved, 0);

    enable = 0;
    repeat (20) tick();
    expect_quiet("R8 disabled", 200);
    enable = 1;
    expect_sample("R8 first after enable", -D);

    enable = 0;
    repeat (20) tick();
    r0_req = 0; ref_sel = 1;
    repeat (5) tick();
    enable = 1;
    expect_sample("R9 select input 1", -D);
    enable = 0;
    repeat (20) tick();
    ref_sel = 0;
    repeat (5) tick();
    enable = 1;
    expect_quiet("R9 stopped input 0", 200);
    r0_req = 1;
    expect_sample("R9 input 0 restarted", -D);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule